// File: doc/BRIEF.md
# Prescaled Wake-Up Timer

This block is a programmable up-counter that produces a wake-up event once a software-chosen count is reached. A clock divider slows the counting, so one count advance spans a configurable number of clock cycles. The count, the threshold and the divider setting all sit behind a small 32-bit register port with valid, write, address and data signals. Reads return their data one cycle after the request.

When the block is enabled and the count is at or above the threshold, it records a sticky wake cause and sets a sticky interrupt state bit. The interrupt line is the state bit gated by an enable bit, and it is registered. Software can raise the state bit on purpose through a test register, and it clears the state by writing one to it. The cause flag is cleared by writing a zero.

Register word addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | enable in bit 0, divider setting in bits [8 +: PRE_W] |
| 1 | Threshold | 32-bit threshold |
| 2 | Count | 32-bit count |
| 3 | Cause | cause flag in bit 0 |
| 4 | Interrupt state | state bit in bit 0 |
| 5 | Interrupt enable | enable bit in bit 0 |
| 6 | Interrupt test | test bit in bit 0, reads as 0 |

Top module: `wake_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero, and `wake_irq` and `wake_cause` are low.
- R2: While the enable bit (control bit 0) is set and the divider setting is P, the count rises by exactly one every P+1 clock cycles. The first step comes P+1 cycles after the enabling write.
- R3: Clearing the enable bit freezes the count. It also resets the divider, so after re-enabling, a full P+1 cycles pass before the next step.
- R4: A write to the count register (address 2) loads the written value. A read of it returns the live count as it stood at the read request, including while the timer runs.
- R5: The divider setting is control bits [8 +: PRE_W], with PRE_W = 12 by default. All other control bits except bit 0 are ignored on write and read back as zero.
- R6: In any cycle where the timer is enabled and count >= threshold (address 1), the cause flag and the interrupt state bit are set at the next edge. While the timer is disabled, no event occurs.
- R7: The cause flag (address 3, bit 0) stays set until a write to address 3 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves it unchanged. `wake_cause` shows the flag.
- R8: The interrupt state bit (address 4, bit 0) is cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R9: Writing 1 to bit 0 of the test register (address 6) sets the interrupt state bit. Bit 0 is the same bit index in the state and test registers.
- R10: `wake_irq` equals the state bit ANDed with the interrupt enable bit (address 5, bit 0), delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| wake_irq | output | 1 | Registered wake-up interrupt |
| wake_cause | output | 1 | Sticky wake cause flag |

## Verification
The counting path is run with several pairs of divider setting and run length, including a divider of zero and a divider of seven. Each frozen count shows whether ticks land every P+1 cycles rather than one cycle early or late. Two runs with the same count and thresholds one apart separate a `>=` compare from a `>` or `==` compare. A zero threshold checks that an event fires on the very first enabled cycle. Directed cases stop and restart the timer mid-period to show that the divider restarts. Further cases write the cause and state registers with both bit values to check the clearing rules, and check the one-cycle lag of the interrupt line.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int PRE_LSB = 8;
  localparam int IRQ_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_THRESH  = 3'd1,
    A_COUNT   = 3'd2,
    A_CAUSE   = 3'd3,
    A_ISTATE  = 3'd4,
    A_IENABLE = 3'd5,
    A_ITEST   = 3'd6
  } wt_addr_e;
endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;

  assign tick = en && (div_q >= pre);

  always_ff @(posedge clk) begin
    if (rst || !en)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assert_idle_div_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> (div_q == '0));
  assert_no_early_tick_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(en) && pre != '0) |-> !tick);
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + 1'b1;
  end

  assign hit = en && (count >= thresh);

  assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(count));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> (count == $past(count) || count == $past(count) + 1'b1));
  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/wt_irq.sv
module wt_irq (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic cause_wr,
  input  logic cause_bit,
  input  logic state_wr,
  input  logic state_bit,
  input  logic ie_wr,
  input  logic ie_bit,
  input  logic test_wr,
  input  logic test_bit,
  output logic cause,
  output logic state,
  output logic ie,
  output logic irq
);
  logic state_set, state_clr, cause_clr;

  assign state_set = hit || (test_wr && test_bit);
  assign state_clr = state_wr && state_bit;
  assign cause_clr = cause_wr && !cause_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= 1'b0;
      state <= 1'b0;
      ie    <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (hit)            cause <= 1'b1;
      else if (cause_clr) cause <= 1'b0;
      if (state_set)      state <= 1'b1;
      else if (state_clr) state <= 1'b0;
      if (ie_wr)          ie <= ie_bit;
      irq <= state && ie;
    end
  end

  assert_event_R6: assert property (@(posedge clk) disable iff (rst)
    hit |=> (state && cause));
  assert_cause_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cause && !cause_clr) |=> cause);
  assert_state_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state && !state_clr) |=> state);
  assert_test_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (test_wr && test_bit) |=> state);
  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(state && ie)));
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int PRE_W = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        wake_irq,
  output logic        wake_cause
);
  import wt_pkg::*;

  localparam int PRE_HI = PRE_LSB + PRE_W;

  logic             en_q;
  logic [PRE_W-1:0] pre_q;
  logic [31:0]      thresh_q;
  logic [31:0]      count;
  logic             tick, hit, state, ie;
  logic             wr_ctrl, wr_thresh, wr_count, wr_cause;
  logic             wr_state, wr_ie, wr_test;
  logic [31:0]      rd_mux;

  initial begin
    if (PRE_HI > DATA_W) $error("PRE_W too wide for the control register");
  end

  always_comb begin
    wr_ctrl   = 1'b0; wr_thresh = 1'b0; wr_count = 1'b0; wr_cause = 1'b0;
    wr_state  = 1'b0; wr_ie     = 1'b0; wr_test  = 1'b0;
    if (reg_valid && reg_write) begin
      case (wt_addr_e'(reg_addr))
        A_CTRL:    wr_ctrl   = 1'b1;
        A_THRESH:  wr_thresh = 1'b1;
        A_COUNT:   wr_count  = 1'b1;
        A_CAUSE:   wr_cause  = 1'b1;
        A_ISTATE:  wr_state  = 1'b1;
        A_IENABLE: wr_ie     = 1'b1;
        A_ITEST:   wr_test   = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      pre_q    <= '0;
      thresh_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        pre_q <= reg_wdata[PRE_LSB +: PRE_W];
      end
      if (wr_thresh) thresh_q <= reg_wdata;
    end
  end

  wt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(en_q), .pre(pre_q), .tick(tick)
  );

  wt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .tick(tick), .load(wr_count),
    .load_val(reg_wdata), .thresh(thresh_q), .count(count), .hit(hit)
  );

  wt_irq u_irq (
    .clk(clk), .rst(rst), .hit(hit),
    .cause_wr(wr_cause), .cause_bit(reg_wdata[0]),
    .state_wr(wr_state), .state_bit(reg_wdata[IRQ_BIT]),
    .ie_wr(wr_ie), .ie_bit(reg_wdata[IRQ_BIT]),
    .test_wr(wr_test), .test_bit(reg_wdata[IRQ_BIT]),
    .cause(wake_cause), .state(state), .ie(ie), .irq(wake_irq)
  );

  always_comb begin
    rd_mux = '0;
    case (wt_addr_e'(reg_addr))
      A_CTRL: begin
        rd_mux[0] = en_q;
        rd_mux[PRE_LSB +: PRE_W] = pre_q;
      end
      A_THRESH:  rd_mux = thresh_q;
      A_COUNT:   rd_mux = count;
      A_CAUSE:   rd_mux[0] = wake_cause;
      A_ISTATE:  rd_mux[IRQ_BIT] = state;
      A_IENABLE: rd_mux[IRQ_BIT] = ie;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                         reg_rdata <= '0;
    else if (reg_valid && !reg_write) reg_rdata <= rd_mux;
  end

  assert_ctrl_mask_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (pre_q == $past(reg_wdata[PRE_LSB +: PRE_W])));
endmodule

// File: tb/sim_wake_timer.sv
`timescale 1ns/1ps
module sim_wake_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_valid, reg_write;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        wake_irq, wake_cause;
  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wake_timer u0 (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_irq(wake_irq), .wake_cause(wake_cause)
  );

  localparam int NV = 6;
  localparam int VP [NV] = '{0, 1, 3, 3, 2, 7};
  localparam int VT [NV] = '{5, 100, 4, 5, 0, 3};
  localparam int VN [NV] = '{9, 20, 19, 19, 0, 30};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk("R1 irq", {31'd0, wake_irq}, 32'd0);
    chk("R1 cause", {31'd0, wake_cause}, 32'd0);
    rd(3'd0, d); chk("R1 ctrl", d, 32'd0);
    rd(3'd1, d); chk("R1 thresh", d, 32'd0);
    rd(3'd2, d); chk("R1 count", d, 32'd0);
    rd(3'd4, d); chk("R1 state", d, 32'd0);

    // R2 / R6 / R10: vector table of divider, threshold and run length
    for (int i = 0; i < NV; i++) begin
      int cnt_exp;
      int ev_exp;
      wr(3'd0, 32'd0);
      wr(3'd2, 32'd0);
      wr(3'd4, 32'd1);
      wr(3'd3, 32'd0);
      wr(3'd1, VT[i]);
      wr(3'd5, 32'd1);
      wr(3'd0, (VP[i] << 8) | 1);
      idle(VN[i]);
      wr(3'd0, 32'd0);
      idle(2);
      cnt_exp = (VN[i] + 1) / (VP[i] + 1);
      ev_exp  = ((VN[i] / (VP[i] + 1)) >= VT[i]) ? 1 : 0;
      rd(3'd2, d); chk("R2 count", d, cnt_exp);
      chk("R6 cause", {31'd0, wake_cause}, ev_exp);
      rd(3'd4, d); chk("R6 state", d, ev_exp);
      chk("R10 irq", {31'd0, wake_irq}, ev_exp);
    end

    // R6: no event while disabled even with count >= threshold
    wr(3'd4, 32'd1); wr(3'd3, 32'd0);
    wr(3'd1, 32'd0); idle(3);
    chk("R6 disabled cause", {31'd0, wake_cause}, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);

    // R4: load and live read
    wr(3'd2, 32'd1234);
    rd(3'd2, d); chk("R4 load", d, 32'd1234);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd1);
    idle(4);
    rd(3'd2, d); chk("R4 live", d, 32'd4);
    wr(3'd0, 32'd0);

    // R3: freeze and divider restart
    wr(3'd2, 32'd0);
    wr(3'd0, (3 << 8) | 1);
    idle(5);
    wr(3'd0, 32'd0);
    idle(3);
    rd(3'd2, d); chk("R3 freeze", d, 32'd1);
    wr(3'd0, (3 << 8) | 1);
    idle(2);
    wr(3'd0, 32'd0);
    rd(3'd2, d); chk("R3 divider reset", d, 32'd1);

    // R5: control field masking
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, d); chk("R5 ctrl mask", d, 32'h000F_FF00);
    wr(3'd0, 32'd0);

    // R7: cause clear rules
    wr(3'd1, 32'd0); wr(3'd0, 32'd1); idle(2); wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R7 set", {31'd0, wake_cause}, 32'd1);
    wr(3'd3, 32'd1);
    chk("R7 write one keeps", {31'd0, wake_cause}, 32'd1);
    wr(3'd3, 32'd0);
    chk("R7 write zero clears", {31'd0, wake_cause}, 32'd0);

    // R8: state write-one-to-clear
    wr(3'd4, 32'd0);
    rd(3'd4, d); chk("R8 write zero keeps", d, 32'd1);
    wr(3'd4, 32'd1);
    rd(3'd4, d); chk("R8 write one clears", d, 32'd0);

    // R9 / R10: test register, enable gating and one-cycle lag
    wr(3'd5, 32'd0);
    wr(3'd6, 32'd1);
    rd(3'd4, d); chk("R9 test sets state", d, 32'd1);
    rd(3'd6, d); chk("R9 test reads zero", d, 32'd0);
    chk("R10 gated by enable", {31'd0, wake_irq}, 32'd0);
    wr(3'd4, 32'd1);
    wr(3'd5, 32'd1);
    idle(2);
    wr(3'd6, 32'd1);
    chk("R10 lag low", {31'd0, wake_irq}, 32'd0);
    idle(1);
    chk("R10 lag high", {31'd0, wake_irq}, 32'd1);

    finish_run();
  end
endmodule